// File: doc/BRIEF.md
# Reference-Ratio Frequency Lock Detector

This block decides whether a recovered clock is frequency-locked to an optional reference clock. Both clocks arrive as toggle lines in the system clock domain. Every transition on a line counts as one edge event. Each line passes through a two-flop synchronizer before anything counts it. The recovered line carries the oscillator divided by a fixed prescale `RDIV`. The block counts its events during a window of `WIN` reference events. It then checks the count against the three expected values `N*WIN/RDIV`, where N is 16, 32 or 128. This tells it which multiple of the reference the oscillator runs at, and how far the oscillator is from that multiple.

The block publishes three results after every window: the ratio it detected, an active-low loss-of-lock flag and a one-cycle reacquire request. A window passes when its count lies inside the lock tolerance of the detected ratio. Lock is declared after two passing windows in a row. One failing window drops it. When the reference stops, a timeout closes the window and reports that no reference is present.

A low level on the lock-to-reference input raises a mode flag and silences reacquire requests. A reset/calibrate input held high long enough freezes the detector. Its release starts a fresh acquisition. A shorter pulse on that input is ignored.

The control FSM has five states:
- SEEK: out of lock, waiting for a passing window.
- PEND: one passing window seen.
- LOCKED: two or more passing windows seen.
- NOREF: the last window matched no ratio, or timed out.
- HOLD: calibration in progress.

The transitions between them are:
- SEEK or NOREF go to PEND on a passing window.
- PEND or LOCKED go to LOCKED on a passing window.
- Any state except HOLD goes to SEEK on a window whose ratio matches but whose count is outside the lock tolerance.
- Any state except HOLD goes to NOREF on a window that matches no ratio or times out.
- Any state goes to HOLD once the calibrate input has been high for `CAL_MIN` cycles.
- HOLD goes to SEEK when the calibrate input falls.

Top module: `refratio_lock_det`

## Requirements
- R1: After reset, `lol_n_o` is low, `ratio_o` is 2'b00, and `reacq_o`, `win_done_o` and `ltr_mode_o` are low.
- R2: A window whose count lies within `RATIO_PPM` of `N*WIN/RDIV` reports `ratio_o` 2'b01 for N=16, 2'b10 for N=32 and 2'b11 for N=128. A count matching none of these reports 2'b00.
- R3: Each transition on either toggle input is one edge event. A window spans `WIN` reference events, counted from the reference event that opens it. Its result is published together with a one-cycle `win_done_o` pulse.
- R4: A window passes when its count deviates from `N*WIN/RDIV` by at most `floor(N*WIN/RDIV*LOCK_PPM/1e6)` counts. A count just outside that limit fails.
- R5: `lol_n_o` rises only at the end of the second consecutive passing window. It stays high while further windows pass.
- R6: A single failing window drives `lol_n_o` low.
- R7: Each failing window gives a one-cycle `reacq_o` pulse with its `win_done_o`, unless lock-to-reference is active. A window with no matching ratio counts as failing.
- R8: While `ltr_n_i` is low, `ltr_mode_o` is high and `reacq_o` stays low.
- R9: If no reference event arrives for `REF_TMO` cycles, the window closes with `ratio_o` 2'b00 and `lol_n_o` low. It raises a reacquire request. The next reference event opens a new window.
- R10: When `cal_i` has been high for `CAL_MIN` cycles, `lol_n_o` goes low and `ratio_o` 2'b00, and the current window is dropped. The falling edge of `cal_i` raises `reacq_o` for one cycle without `win_done_o`, and acquisition restarts.
- R11: A `cal_i` pulse shorter than `CAL_MIN` cycles has no effect on lock, ratio or the running window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tog_i | input | 1 | Reference toggle line, one event per transition |
| rec_tog_i | input | 1 | Prescaled recovered-clock toggle line |
| ltr_n_i | input | 1 | Active-low lock-to-reference request |
| cal_i | input | 1 | Reset/calibrate request, active high |
| lol_n_o | output | 1 | Loss-of-lock flag, low while out of lock |
| ratio_o | output | 2 | Detected reference ratio code |
| reacq_o | output | 1 | One-cycle reacquire request |
| ltr_mode_o | output | 1 | Lock-to-reference mode active |
| win_done_o | output | 1 | One-cycle strobe marking a published window result |

## Verification
The hardest case to reach from the ports is a count that sits exactly on the lock tolerance, or one count past it. Counts only form over a whole window of reference events. The stimulus therefore emits a fixed number of recovered events between consecutive reference toggles, which keeps each window total exact. It adds or removes a chosen number of events in the first interval to land precisely on either side of the limit. Reference timeout and calibration are reached by stopping the reference line between windows, or by holding the calibrate line across one of those pauses. Each such pause stays shorter than the timeout, except the one meant to trigger it.

// File: rtl/refratio_pkg.sv
package refratio_pkg;

    typedef enum logic [2:0] {
        ST_SEEK   = 3'd0,
        ST_PEND   = 3'd1,
        ST_LOCKED = 3'd2,
        ST_NOREF  = 3'd3,
        ST_HOLD   = 3'd4
    } lock_state_e;

    typedef enum logic [1:0] {
        RATIO_NONE = 2'b00,
        RATIO_16   = 2'b01,
        RATIO_32   = 2'b10,
        RATIO_128  = 2'b11
    } ratio_e;

    localparam int unsigned NUM_DIV = 3;

endpackage

// File: rtl/refratio_sync.sv
module refratio_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/refratio_window.sv
module refratio_window #(
    parameter int unsigned WIN     = 4096,
    parameter int unsigned REF_TMO = 8192,
    parameter int unsigned CW      = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic          ref_lvl_i,
    input  logic          rec_lvl_i,
    output logic          done_o,
    output logic          timeout_o,
    output logic [CW-1:0] count_o
);

    localparam int unsigned RW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int unsigned TW = $clog2(REF_TMO + 1);

    logic          ref_d, rec_d;
    logic          ref_ev, rec_ev;
    logic          armed_q;
    logic [RW-1:0] ref_cnt_q;
    logic [CW-1:0] rec_cnt_q;
    logic [CW-1:0] rec_inc;
    logic [TW-1:0] tmo_q;

    assign ref_ev  = ref_lvl_i ^ ref_d;
    assign rec_ev  = rec_lvl_i ^ rec_d;
    assign rec_inc = (&rec_cnt_q) ? rec_cnt_q : rec_cnt_q + CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_d     <= 1'b0;
            rec_d     <= 1'b0;
            armed_q   <= 1'b0;
            ref_cnt_q <= '0;
            rec_cnt_q <= '0;
            tmo_q     <= '0;
            done_o    <= 1'b0;
            timeout_o <= 1'b0;
            count_o   <= '0;
        end else begin
            ref_d     <= ref_lvl_i;
            rec_d     <= rec_lvl_i;
            done_o    <= 1'b0;
            timeout_o <= 1'b0;
            if (restart_i) begin
                armed_q   <= 1'b0;
                ref_cnt_q <= '0;
                rec_cnt_q <= '0;
                tmo_q     <= '0;
            end else if (ref_ev) begin
                tmo_q <= '0;
                if (!armed_q) begin
                    armed_q   <= 1'b1;
                    ref_cnt_q <= '0;
                    rec_cnt_q <= '0;
                end else if (ref_cnt_q == RW'(WIN - 1)) begin
                    done_o    <= 1'b1;
                    count_o   <= rec_cnt_q;
                    ref_cnt_q <= '0;
                    rec_cnt_q <= rec_ev ? CW'(1) : '0;
                end else begin
                    ref_cnt_q <= ref_cnt_q + RW'(1);
                    if (rec_ev) rec_cnt_q <= rec_inc;
                end
            end else if (tmo_q == TW'(REF_TMO - 1)) begin
                done_o    <= 1'b1;
                timeout_o <= 1'b1;
                count_o   <= '0;
                armed_q   <= 1'b0;
                ref_cnt_q <= '0;
                rec_cnt_q <= '0;
                tmo_q     <= '0;
            end else begin
                tmo_q <= tmo_q + TW'(1);
                if (armed_q && rec_ev) rec_cnt_q <= rec_inc;
            end
        end
    end

endmodule

// File: rtl/refratio_judge.sv
module refratio_judge
    import refratio_pkg::*;
#(
    parameter int unsigned WIN       = 4096,
    parameter int unsigned RDIV      = 8,
    parameter int unsigned LOCK_PPM  = 650,
    parameter int unsigned RATIO_PPM = 2000,
    parameter int unsigned CW        = 18
) (
    input  logic [CW-1:0] count_i,
    input  logic          timeout_i,
    output ratio_e        ratio_o,
    output logic          good_o
);

    logic [63:0]         cnt64;
    logic [NUM_DIV-1:0]  hit_ratio;
    logic [NUM_DIV-1:0]  hit_lock;

    assign cnt64 = 64'(count_i);

    for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
        localparam longint unsigned DIV  = (i == 0) ? 64'd16 : ((i == 1) ? 64'd32 : 64'd128);
        localparam longint unsigned EXP  = DIV * 64'(WIN) / 64'(RDIV);
        localparam longint unsigned RTOL = EXP * 64'(RATIO_PPM) / 64'd1000000;
        localparam longint unsigned LTOL = EXP * 64'(LOCK_PPM) / 64'd1000000;
        localparam longint unsigned RLO  = (EXP > RTOL) ? EXP - RTOL : 64'd0;
        localparam longint unsigned LLO  = (EXP > LTOL) ? EXP - LTOL : 64'd0;
        assign hit_ratio[i] = !timeout_i && (cnt64 >= RLO) && (cnt64 <= EXP + RTOL);
        assign hit_lock[i]  = (cnt64 >= LLO) && (cnt64 <= EXP + LTOL);
    end

    always_comb begin
        ratio_o = RATIO_NONE;
        good_o  = 1'b0;
        if (hit_ratio[0]) begin
            ratio_o = RATIO_16;
            good_o  = hit_lock[0];
        end else if (hit_ratio[1]) begin
            ratio_o = RATIO_32;
            good_o  = hit_lock[1];
        end else if (hit_ratio[2]) begin
            ratio_o = RATIO_128;
            good_o  = hit_lock[2];
        end
    end

endmodule

// File: rtl/refratio_lock_det.sv
module refratio_lock_det
    import refratio_pkg::*;
#(
    parameter int unsigned WIN       = 4096,
    parameter int unsigned RDIV      = 8,
    parameter int unsigned LOCK_PPM  = 650,
    parameter int unsigned RATIO_PPM = 2000,
    parameter int unsigned REF_TMO   = 8192,
    parameter int unsigned CAL_MIN   = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tog_i,
    input  logic       rec_tog_i,
    input  logic       ltr_n_i,
    input  logic       cal_i,
    output logic       lol_n_o,
    output logic [1:0] ratio_o,
    output logic       reacq_o,
    output logic       ltr_mode_o,
    output logic       win_done_o
);

    localparam int unsigned CW    = $clog2(128 * WIN / RDIV) + 2;
    localparam int unsigned CAL_W = $clog2(CAL_MIN + 1);

    logic [3:0]       sync_q;
    logic             ref_s, rec_s, ltr_s, cal_s;
    logic             done_w, timeout_w;
    logic [CW-1:0]    count_w;
    ratio_e           ratio_w;
    logic             good_w;
    logic [CAL_W-1:0] cal_cnt_q;
    logic             cal_full;
    logic             pub;
    lock_state_e      state_q, state_nx;
    ratio_e           ratio_q;

    // bit order: {cal, ltr_n, rec, ref}; ltr_n idles high
    refratio_sync #(.W(4), .RST_VAL(4'b0100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cal_i, ltr_n_i, rec_tog_i, ref_tog_i}),
        .q_o   (sync_q)
    );

    assign ref_s = sync_q[0];
    assign rec_s = sync_q[1];
    assign ltr_s = sync_q[2];
    assign cal_s = sync_q[3];

    refratio_window #(.WIN(WIN), .REF_TMO(REF_TMO), .CW(CW)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (state_q == ST_HOLD),
        .ref_lvl_i (ref_s),
        .rec_lvl_i (rec_s),
        .done_o    (done_w),
        .timeout_o (timeout_w),
        .count_o   (count_w)
    );

    refratio_judge #(
        .WIN(WIN), .RDIV(RDIV), .LOCK_PPM(LOCK_PPM), .RATIO_PPM(RATIO_PPM), .CW(CW)
    ) u_judge (
        .count_i   (count_w),
        .timeout_i (timeout_w),
        .ratio_o   (ratio_w),
        .good_o    (good_w)
    );

    // calibrate qualification: count high cycles, saturate at CAL_MIN
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_cnt_q <= '0;
        end else if (!cal_s) begin
            cal_cnt_q <= '0;
        end else if (cal_cnt_q != CAL_W'(CAL_MIN)) begin
            cal_cnt_q <= cal_cnt_q + CAL_W'(1);
        end
    end

    assign cal_full = (cal_cnt_q == CAL_W'(CAL_MIN));
    assign pub      = done_w && (state_q != ST_HOLD) && !cal_full;

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (!cal_s) state_nx = ST_SEEK;
            end
            ST_SEEK, ST_NOREF: begin
                if (cal_full)                   state_nx = ST_HOLD;
                else if (pub) begin
                    if (ratio_w == RATIO_NONE)  state_nx = ST_NOREF;
                    else if (good_w)            state_nx = ST_PEND;
                    else                        state_nx = ST_SEEK;
                end
            end
            ST_PEND, ST_LOCKED: begin
                if (cal_full)                   state_nx = ST_HOLD;
                else if (pub) begin
                    if (ratio_w == RATIO_NONE)  state_nx = ST_NOREF;
                    else if (good_w)            state_nx = ST_LOCKED;
                    else                        state_nx = ST_SEEK;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEEK;
        else        state_q <= state_nx;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lol_n_o    <= 1'b0;
            ratio_q    <= RATIO_NONE;
            reacq_o    <= 1'b0;
            ltr_mode_o <= 1'b0;
            win_done_o <= 1'b0;
        end else begin
            lol_n_o    <= (state_nx == ST_LOCKED);
            win_done_o <= pub;
            ltr_mode_o <= !ltr_s;
            reacq_o    <= ltr_s && ((pub && !good_w) ||
                                    (state_q == ST_HOLD && state_nx == ST_SEEK));
            if (state_nx == ST_HOLD) ratio_q <= RATIO_NONE;
            else if (pub)            ratio_q <= ratio_w;
        end
    end

    assign ratio_o = ratio_q;

endmodule

// File: rtl/refratio_lock_det_chk.sv
module refratio_lock_det_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lol_n_o,
    input logic [1:0] ratio_o,
    input logic       reacq_o,
    input logic       ltr_mode_o,
    input logic       win_done_o
);

    // R5
    locked_has_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lol_n_o |-> (ratio_o != 2'b00));

    // R5
    lock_at_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lol_n_o) |-> win_done_o);

    // R6
    drop_at_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lol_n_o) |-> (win_done_o || ratio_o == 2'b00));

    // R7
    reacq_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reacq_o |-> !lol_n_o);

    // R8
    ltr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ltr_mode_o |-> !reacq_o);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_done_o |=> !win_done_o);

endmodule

bind refratio_lock_det refratio_lock_det_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lol_n_o    (lol_n_o),
    .ratio_o    (ratio_o),
    .reacq_o    (reacq_o),
    .ltr_mode_o (ltr_mode_o),
    .win_done_o (win_done_o)
);

// File: tb/refratio_lock_det_bench.sv
module refratio_lock_det_bench;

    localparam int unsigned WIN       = 64;
    localparam int unsigned RDIV      = 8;
    localparam int unsigned LOCK_PPM  = 20000;
    localparam int unsigned RATIO_PPM = 100000;
    localparam int unsigned REF_TMO   = 200;
    localparam int unsigned CAL_MIN   = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_t = 1'b0;
    logic       rec_t = 1'b0;
    logic       ltr_n = 1'b1;
    logic       cal = 1'b0;
    logic       lol_n;
    logic [1:0] ratio;
    logic       reacq;
    logic       ltr_mode;
    logic       win_done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [1:0] ratio;
        logic       lol_n;
        logic       reacq;
        string      req;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    refratio_lock_det #(
        .WIN(WIN), .RDIV(RDIV), .LOCK_PPM(LOCK_PPM), .RATIO_PPM(RATIO_PPM),
        .REF_TMO(REF_TMO), .CAL_MIN(CAL_MIN)
    ) u_refratio_lock_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tog_i  (ref_t),
        .rec_tog_i  (rec_t),
        .ltr_n_i    (ltr_n),
        .cal_i      (cal),
        .lol_n_o    (lol_n),
        .ratio_o    (ratio),
        .reacq_o    (reacq),
        .ltr_mode_o (ltr_mode),
        .win_done_o (win_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm();
        ref_t = ~ref_t;
        tick(2);
    endtask

    // one window: WIN intervals of m recovered events, extra added to the first
    task automatic run_window(input int m, input int extra, input logic [1:0] e_ratio,
                              input logic e_lol, input logic e_reacq, input string req);
        exp_t e;
        e.ratio = e_ratio; e.lol_n = e_lol; e.reacq = e_reacq; e.req = req;
        sb_q.push_back(e);
        for (int k = 0; k < int'(WIN); k++) begin
            for (int j = 0; j < m + ((k == 0) ? extra : 0); j++) begin
                rec_t = ~rec_t;
                tick(1);
            end
            tick(2);
            ref_t = ~ref_t;
            tick(1);
        end
        tick(6);
    endtask

    // monitor: compare each published window against the scoreboard
    always @(negedge clk) begin
        if (rst_n && win_done && !finished) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R3", "unexpected window result", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(ratio == e.ratio, e.req, "ratio_o", int'(ratio), int'(e.ratio));
                chk(lol_n == e.lol_n, e.req, "lol_n_o", int'(lol_n), int'(e.lol_n));
                chk(reacq == e.reacq, e.req, "reacq_o", int'(reacq), int'(e.reacq));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WATCHDOG", "run did not complete", 0, 1);
        finish_up();
    end

    initial begin
        bit seen;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        // R1 reset state
        chk(lol_n == 1'b0, "R1", "lol_n_o", int'(lol_n), 0);
        chk(ratio == 2'b00, "R1", "ratio_o", int'(ratio), 0);
        chk(reacq == 1'b0, "R1", "reacq_o", int'(reacq), 0);
        chk(win_done == 1'b0, "R1", "win_done_o", int'(win_done), 0);
        chk(ltr_mode == 1'b0, "R1", "ltr_mode_o", int'(ltr_mode), 0);

        arm();
        // R2 R3 R5: ratio 16, lock after two windows
        run_window(2, 0, 2'b01, 1'b0, 1'b0, "R2");
        run_window(2, 0, 2'b01, 1'b1, 1'b0, "R5");
        run_window(2, 0, 2'b01, 1'b1, 1'b0, "R5");
        // R6 R7: deviation +5 beyond tolerance 2
        run_window(2, 5, 2'b01, 1'b0, 1'b1, "R6");
        run_window(2, 0, 2'b01, 1'b0, 1'b0, "R5");
        run_window(2, 0, 2'b01, 1'b1, 1'b0, "R5");
        // R4 boundaries
        run_window(2, 2, 2'b01, 1'b1, 1'b0, "R4");
        run_window(2, -2, 2'b01, 1'b1, 1'b0, "R4");
        run_window(2, 3, 2'b01, 1'b0, 1'b1, "R4");
        // R2 ratio 32 and 128
        run_window(4, 0, 2'b10, 1'b0, 1'b0, "R2");
        run_window(4, 0, 2'b10, 1'b1, 1'b0, "R2");
        run_window(16, 0, 2'b11, 1'b1, 1'b0, "R2");
        run_window(16, 0, 2'b11, 1'b1, 1'b0, "R2");
        // R2 R7: no ratio matches
        run_window(1, 0, 2'b00, 1'b0, 1'b1, "R7");
        // R8 lock-to-reference
        ltr_n = 1'b0;
        tick(5);
        chk(ltr_mode == 1'b1, "R8", "ltr_mode_o", int'(ltr_mode), 1);
        run_window(1, 0, 2'b00, 1'b0, 1'b0, "R8");
        ltr_n = 1'b1;
        tick(5);
        chk(ltr_mode == 1'b0, "R8", "ltr_mode_o released", int'(ltr_mode), 0);
        // R9 reference timeout
        begin
            exp_t e;
            e.ratio = 2'b00; e.lol_n = 1'b0; e.reacq = 1'b1; e.req = "R9";
            sb_q.push_back(e);
        end
        tick(REF_TMO + 50);
        arm();
        run_window(2, 0, 2'b01, 1'b0, 1'b0, "R9");
        run_window(2, 0, 2'b01, 1'b1, 1'b0, "R9");
        // R11 short calibrate pulse ignored
        cal = 1'b1;
        tick(3);
        cal = 1'b0;
        tick(10);
        chk(lol_n == 1'b1, "R11", "lol_n_o after short pulse", int'(lol_n), 1);
        chk(ratio == 2'b01, "R11", "ratio_o after short pulse", int'(ratio), 1);
        run_window(2, 0, 2'b01, 1'b1, 1'b0, "R11");
        // R10 full calibrate
        cal = 1'b1;
        tick(CAL_MIN + 10);
        chk(lol_n == 1'b0, "R10", "lol_n_o in hold", int'(lol_n), 0);
        chk(ratio == 2'b00, "R10", "ratio_o in hold", int'(ratio), 0);
        cal = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 10; k++) begin
            tick(1);
            if (reacq && !win_done) seen = 1'b1;
        end
        chk(seen, "R10", "reacq_o on release", int'(seen), 1);
        arm();
        run_window(2, 0, 2'b01, 1'b0, 1'b0, "R10");
        run_window(2, 0, 2'b01, 1'b1, 1'b0, "R10");
        tick(10);
        chk(sb_q.size() == 0, "R3", "pending results", sb_q.size(), 0);
        finish_up();
    end

endmodule